// File: doc/BRIEF.md
# MFM Track Format Sequencer

This block produces, one byte at a time, the complete formatted image of a single MFM floppy track for a drive emulator that has to lay out a fresh track. A start strobe latches the cylinder number and the head. The block then walks through the track layout:

- a pre-index gap;
- an index mark;
- a post-index gap;
- sixteen sectors, each with an ID field and a data field;
- trailing filler up to the nominal track length.

Bytes move to a downstream MFM encoder through a ready handshake. Each byte carries a flag that tells the encoder to leave out a clock bit. This flag is set only on the special sync bytes in front of the address marks.

Sector IDs on head 0 run in natural order. Head 1 is rotated by a skew, so its physical order starts at sector 14. The ID and data fields each end in a CRC-16. Data payload bytes come from a plain input port. The block pulls a payload byte each time the encoder takes a data-field byte.

Top module: `mfm_track_seq`

## Requirements
- R1: After reset, out_valid, out_mark, pay_take and done are all low.
- R2: A start strobe while idle begins a track with this preamble:
  - 81 bytes of 0x4E;
  - 12 bytes of 0x00;
  - 3 bytes of 0xC2 with out_mark high;
  - one byte of 0xFC;
  - 48 bytes of 0x4E.
- R3: Each sector is sent as the following sequence:
  - 12 bytes of 0x00;
  - 3 bytes of 0xA1 with the mark flag;
  - 0xFE;
  - the ID bytes: cylinder, head (0 or 1), sector ID, size code 0x01;
  - 2 CRC bytes;
  - 24 bytes of 0x4E;
  - 12 bytes of 0x00;
  - 3 bytes of 0xA1 with the mark flag;
  - 0xFB;
  - 256 payload bytes;
  - 2 CRC bytes;
  - 49 bytes of 0x4E.
- R4: Sector IDs in physical order are 1..16 on head 0, and 14, 15, 16, 1, 2 … 13 on head 1.
- R5: Each CRC is CRC-16 with polynomial 0x1021 and preset 0xFFFF. It covers the three 0xA1 bytes, the mark byte and the field, and is sent high byte first.
- R6: After the last sector, 0x4E is sent until exactly 6250 bytes have been accepted. One cycle after the final byte is accepted, done is high for exactly one cycle and out_valid is low.
- R7: A byte is accepted only in a cycle where out_valid and rdy are both high. While rdy is low, the presented byte and flag stay unchanged.
- R8: pay_take is high exactly on accepted data-field bytes, and out_byte then equals pay_data. Each sector consumes 256 payload bytes.
- R9: A start strobe while a track is in progress has no effect on the emitted stream.
- R10: out_mark is high only on the three 0xC2 bytes and on each group of three 0xA1 bytes. It is low on every other byte.
- R11: track and side are sampled at start. Changes to them during a track do not alter the ID bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a track (accepted only when idle) |
| track | input | 7 | Cylinder number written into the ID fields |
| side | input | 1 | Head number; selects the sector skew |
| rdy | input | 1 | Downstream encoder takes the presented byte |
| pay_data | input | 8 | Payload byte for the data field |
| out_byte | output | 8 | Presented track byte |
| out_valid | output | 1 | A track byte is being presented |
| out_mark | output | 1 | Presented byte is a missing-clock sync mark |
| pay_take | output | 1 | Payload byte consumed this cycle |
| done | output | 1 | One-cycle pulse after the last track byte |

## Verification
The hardest situation to reach is a stall: rdy dropping in the middle of a two-byte CRC, or at the border between segments, while track, side and start are also disturbed. A wrong counter or CRC step shows up only there. The stimulus draws rdy from a fixed-seed random source at several duty levels, so stalls land on every segment boundary over a full 6250-byte track. One run also toggles start, track and side a thousand bytes in. Each accepted byte is compared with an image that the bench builds on its own, including its own CRC and sector order for both heads.

// File: rtl/mfm_fmt_pkg.sv
package mfm_fmt_pkg;

  typedef enum logic [4:0] {
    SEG_IDLE, SEG_GAP0, SEG_SYNC_I, SEG_MK_I, SEG_IAM, SEG_GAP1,
    SEG_SYNC_H, SEG_MK_H, SEG_IDAM, SEG_ID, SEG_CRC_H, SEG_GAP2,
    SEG_SYNC_D, SEG_MK_D, SEG_DAM, SEG_DATA, SEG_CRC_D, SEG_GAP3,
    SEG_GAP4B
  } seg_t;

  typedef enum logic [1:0] {
    KIND_FIX, KIND_ID, KIND_DATA, KIND_CRC
  } kind_t;

  // One byte of CRC-16, polynomial 0x1021, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  // Logical sector ID for a physical slot: interleave step plus head skew.
  function automatic logic [7:0] sector_id(input int slot, input logic hd,
                                           input int n, input int first,
                                           input int skew, input int il);
    int off;
    off = hd ? (skew - first) : 0;
    return 8'(((slot * il + off) % n) + first);
  endfunction

endpackage

// File: rtl/mfm_crc_unit.sv
module mfm_crc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import mfm_fmt_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= 16'hFFFF;
    else if (init)  crc_q <= 16'hFFFF;
    else if (en)    crc_q <= crc16_step(crc_q, din);
  end

  assign crc = crc_q;

  // R5: the CRC only moves on a covered byte or a preset
  p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !en) |=> $stable(crc_q));
  p_crc_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == 16'hFFFF));

endmodule

// File: rtl/mfm_seg_decode.sv
module mfm_seg_decode #(
  parameter int CW           = 9,
  parameter int GAP0_LEN     = 81,
  parameter int GAP1_LEN     = 48,
  parameter int GAP2_LEN     = 24,
  parameter int GAP3_LEN     = 49,
  parameter int SYNC_LEN     = 12,
  parameter int SECTOR_BYTES = 256
) (
  input  mfm_fmt_pkg::seg_t  seg,
  input  logic               last_slot,
  output logic [CW-1:0]      len,
  output logic [7:0]         fill,
  output logic               mark,
  output mfm_fmt_pkg::kind_t kind,
  output mfm_fmt_pkg::seg_t  nxt
);
  import mfm_fmt_pkg::*;

  always_comb begin
    len  = CW'(1);
    fill = 8'h4E;
    mark = 1'b0;
    kind = KIND_FIX;
    nxt  = SEG_IDLE;
    unique case (seg)
      SEG_IDLE:   nxt = SEG_IDLE;
      SEG_GAP0:   begin len = CW'(GAP0_LEN); nxt = SEG_SYNC_I; end
      SEG_SYNC_I: begin len = CW'(SYNC_LEN); fill = 8'h00; nxt = SEG_MK_I; end
      SEG_MK_I:   begin len = CW'(3); fill = 8'hC2; mark = 1'b1; nxt = SEG_IAM; end
      SEG_IAM:    begin fill = 8'hFC; nxt = SEG_GAP1; end
      SEG_GAP1:   begin len = CW'(GAP1_LEN); nxt = SEG_SYNC_H; end
      SEG_SYNC_H: begin len = CW'(SYNC_LEN); fill = 8'h00; nxt = SEG_MK_H; end
      SEG_MK_H:   begin len = CW'(3); fill = 8'hA1; mark = 1'b1; nxt = SEG_IDAM; end
      SEG_IDAM:   begin fill = 8'hFE; nxt = SEG_ID; end
      SEG_ID:     begin len = CW'(4); kind = KIND_ID; nxt = SEG_CRC_H; end
      SEG_CRC_H:  begin len = CW'(2); kind = KIND_CRC; nxt = SEG_GAP2; end
      SEG_GAP2:   begin len = CW'(GAP2_LEN); nxt = SEG_SYNC_D; end
      SEG_SYNC_D: begin len = CW'(SYNC_LEN); fill = 8'h00; nxt = SEG_MK_D; end
      SEG_MK_D:   begin len = CW'(3); fill = 8'hA1; mark = 1'b1; nxt = SEG_DAM; end
      SEG_DAM:    begin fill = 8'hFB; nxt = SEG_DATA; end
      SEG_DATA:   begin len = CW'(SECTOR_BYTES); kind = KIND_DATA; nxt = SEG_CRC_D; end
      SEG_CRC_D:  begin len = CW'(2); kind = KIND_CRC; nxt = SEG_GAP3; end
      SEG_GAP3:   begin len = CW'(GAP3_LEN); nxt = last_slot ? SEG_GAP4B : SEG_SYNC_H; end
      SEG_GAP4B:  nxt = SEG_GAP4B;
      default:    nxt = SEG_IDLE;
    endcase
  end

endmodule

// File: rtl/mfm_track_seq.sv
module mfm_track_seq #(
  parameter int TRK_W        = 7,
  parameter int SECTORS      = 16,
  parameter int FIRST_ID     = 1,
  parameter int SKEW         = 14,
  parameter int INTERLEAVE   = 1,
  parameter int SECTOR_BYTES = 256,
  parameter int SIZE_CODE    = 1,
  parameter int GAP0_LEN     = 81,
  parameter int GAP1_LEN     = 48,
  parameter int GAP2_LEN     = 24,
  parameter int GAP3_LEN     = 49,
  parameter int SYNC_LEN     = 12,
  parameter int TRACK_BYTES  = 6250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TRK_W-1:0] track,
  input  logic             side,
  input  logic             rdy,
  input  logic [7:0]       pay_data,
  output logic [7:0]       out_byte,
  output logic             out_valid,
  output logic             out_mark,
  output logic             pay_take,
  output logic             done
);
  import mfm_fmt_pkg::*;

  localparam int CW = $clog2(SECTOR_BYTES) + 1;
  localparam int TW = $clog2(TRACK_BYTES + 1);
  localparam int SW = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  seg_t             seg_q;
  logic [CW-1:0]    cnt_q;
  logic [TW-1:0]    total_q;
  logic [SW-1:0]    slot_q;
  logic             busy_q, done_q, side_q;
  logic [TRK_W-1:0] trk_q;

  // Named internal events for the assertions
  logic          accept, seg_end, total_last, last_slot, crc_init, crc_en;
  logic [CW-1:0] dec_len;
  logic [7:0]    dec_fill, sec_id;
  logic          dec_mark;
  kind_t         dec_kind;
  seg_t          dec_next;
  logic [15:0]   crc;

  mfm_seg_decode #(
    .CW(CW), .GAP0_LEN(GAP0_LEN), .GAP1_LEN(GAP1_LEN), .GAP2_LEN(GAP2_LEN),
    .GAP3_LEN(GAP3_LEN), .SYNC_LEN(SYNC_LEN), .SECTOR_BYTES(SECTOR_BYTES)
  ) u_dec (
    .seg(seg_q), .last_slot(last_slot), .len(dec_len), .fill(dec_fill),
    .mark(dec_mark), .kind(dec_kind), .nxt(dec_next)
  );

  assign accept     = busy_q & rdy;
  assign total_last = (total_q == TW'(TRACK_BYTES - 1));
  assign last_slot  = (slot_q == SW'(SECTORS - 1));
  assign seg_end    = (seg_q == SEG_GAP4B) ? total_last : (cnt_q == dec_len - CW'(1));
  assign sec_id     = sector_id(int'(slot_q), side_q, SECTORS, FIRST_ID, SKEW, INTERLEAVE);

  // CRC is preset during each sync run and covers marks, AM byte and field
  assign crc_init = (seg_q == SEG_SYNC_H) || (seg_q == SEG_SYNC_D);
  assign crc_en   = accept && (seg_q inside {SEG_MK_H, SEG_IDAM, SEG_ID,
                                             SEG_MK_D, SEG_DAM, SEG_DATA});

  mfm_crc_unit u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(out_byte), .crc(crc)
  );

  always_comb begin
    unique case (dec_kind)
      KIND_ID: begin
        unique case (cnt_q[1:0])
          2'd0:    out_byte = 8'(trk_q);
          2'd1:    out_byte = {7'd0, side_q};
          2'd2:    out_byte = sec_id;
          default: out_byte = 8'(SIZE_CODE);
        endcase
      end
      KIND_DATA: out_byte = pay_data;
      KIND_CRC:  out_byte = cnt_q[0] ? crc[7:0] : crc[15:8];
      default:   out_byte = dec_fill;
    endcase
  end

  assign out_valid = busy_q;
  assign out_mark  = busy_q & dec_mark;
  assign pay_take  = accept && (dec_kind == KIND_DATA);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q   <= SEG_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
      slot_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      side_q  <= 1'b0;
      trk_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          seg_q   <= SEG_GAP0;
          cnt_q   <= '0;
          total_q <= '0;
          slot_q  <= '0;
          trk_q   <= track;
          side_q  <= side;
        end
      end else if (accept) begin
        total_q <= total_q + TW'(1);
        if (total_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          seg_q  <= SEG_IDLE;
        end else if (seg_end) begin
          seg_q <= dec_next;
          cnt_q <= '0;
          if (seg_q == SEG_GAP3 && !last_slot) slot_q <= slot_q + SW'(1);
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R7: no progress without ready
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rdy) |=> ($stable(seg_q) && $stable(cnt_q) && $stable(total_q)));
  // R10: missing-clock flag only on sync mark bytes
  p_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_mark |-> (out_byte == 8'hA1 || out_byte == 8'hC2));
  // R6: done follows the final byte and is a single pulse
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(total_q) == TW'(TRACK_BYTES - 1) && !busy_q));
  p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_total_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (total_q < TW'(TRACK_BYTES)));
  // R4: slot index stays within the sector count
  p_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(slot_q) < SECTORS));
  // R11 / R9: latched track and head cannot change mid-track
  p_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(trk_q) && $stable(side_q)));

endmodule

// File: tb/mfm_track_seq_test.sv
module mfm_track_seq_test;

  localparam int NB = 6250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] track = '0;
  logic       side = 1'b0;
  logic       rdy = 1'b0;
  logic [7:0] pay_data = '0;
  logic [7:0] out_byte;
  logic       out_valid, out_mark, pay_take, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0] eb [NB];
  logic       em [NB];
  logic       ed [NB];
  int         ep;

  mfm_track_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .track(track), .side(side),
    .rdy(rdy), .pay_data(pay_data), .out_byte(out_byte), .out_valid(out_valid),
    .out_mark(out_mark), .pay_take(pay_take), .done(done)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act cycles %0d exp < 190000", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    repeat (8) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic logic [7:0] pay_val(input int k, input int t);
    return 8'((k * 37 + t * 11 + 5) & 255);
  endfunction

  task automatic put(input logic [7:0] b, input logic m, input logic d);
    eb[ep] = b; em[ep] = m; ed[ep] = d; ep++;
  endtask

  task automatic put_n(input int n, input logic [7:0] b, input logic m);
    for (int i = 0; i < n; i++) put(b, m, 1'b0);
  endtask

  // Expected track image from R2, R3, R4, R5, R6, R10
  task automatic build(input int t, input logic s);
    int k;
    logic [15:0] c;
    logic [7:0] id, f;
    ep = 0; k = 0;
    put_n(81, 8'h4E, 0); put_n(12, 8'h00, 0); put_n(3, 8'hC2, 1);
    put(8'hFC, 0, 0); put_n(48, 8'h4E, 0);
    for (int sl = 0; sl < 16; sl++) begin
      id = s ? ((sl < 3) ? 8'(sl + 14) : 8'(sl - 2)) : 8'(sl + 1);
      put_n(12, 8'h00, 0); put_n(3, 8'hA1, 1); put(8'hFE, 0, 0);
      c = 16'hFFFF;
      c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1);
      c = ref_crc(c, 8'hFE);
      c = ref_crc(c, 8'(t)); put(8'(t), 0, 0);
      c = ref_crc(c, {7'd0, s}); put({7'd0, s}, 0, 0);
      c = ref_crc(c, id); put(id, 0, 0);
      c = ref_crc(c, 8'h01); put(8'h01, 0, 0);
      put(c[15:8], 0, 0); put(c[7:0], 0, 0);
      put_n(24, 8'h4E, 0); put_n(12, 8'h00, 0); put_n(3, 8'hA1, 1);
      put(8'hFB, 0, 0);
      c = 16'hFFFF;
      c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1); c = ref_crc(c, 8'hA1);
      c = ref_crc(c, 8'hFB);
      for (int j = 0; j < 256; j++) begin
        f = pay_val(k, t); k++;
        c = ref_crc(c, f); put(f, 0, 1);
      end
      put(c[15:8], 0, 0); put(c[7:0], 0, 0);
      put_n(49, 8'h4E, 0);
    end
    while (ep < NB) put(8'h4E, 0, 0);
  endtask

  task automatic run_track(input int t, input logic s, input int pct, input bit disturb);
    int acc, pidx, guard;
    logic stall_prev;
    logic [7:0] sb;
    logic sm;
    bit seen_done;
    build(t, s);
    acc = 0; pidx = 0; guard = 0; stall_prev = 0; sb = 0; sm = 0; seen_done = 0;
    @(negedge clk);
    track = 7'(t); side = s; start = 1'b1; rdy = 1'b0;
    while (!seen_done && guard < 60000) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      if (disturb && acc == 1000) begin
        start = 1'b1;               // R9: strobe while busy
        track = ~track; side = ~side; // R11: inputs move mid-track
      end
      rdy = ($urandom % 100) < pct;
      pay_data = pay_val(pidx, t);
      #1;
      if (done) begin
        seen_done = 1;
        // R6: total count and done timing
        check(acc == NB && !out_valid, "R6 length/done", acc, NB);
      end else if (out_valid) begin
        if (stall_prev)  // R7: held byte while not ready
          check(out_byte == sb && out_mark == sm, "R7 hold", out_byte, sb);
        stall_prev = !rdy; sb = out_byte; sm = out_mark;
        if (rdy) begin
          if (acc < NB) begin
            // R2 R3 R4 R5 R10 R11: byte and mark flag
            check(out_byte == eb[acc] && out_mark == em[acc], "R3 byte/mark",
                  {out_mark, out_byte}, {em[acc], eb[acc]});
            // R8: payload handshake
            check(pay_take == ed[acc], "R8 pay_take", pay_take, ed[acc]);
          end else begin
            check(0, "R6 overrun", acc, NB);
          end
          if (pay_take) pidx++;
          acc++;
        end else begin
          check(!pay_take, "R8 no take while stalled", pay_take, 0);
        end
      end
    end
    if (!seen_done) check(0, "R6 no done", acc, NB);
    check(pidx == 4096, "R8 payload count", pidx, 4096);
    @(negedge clk); #1;
    check(!done && !out_valid, "R6 single done pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(!out_valid && !out_mark && !pay_take && !done, "R1 reset",
          {out_valid, out_mark, pay_take, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && !done, "R1 idle after reset", out_valid, 0);
    run_track(0, 1'b0, 100, 1'b0);   // head 0, no stalls
    run_track(76, 1'b1, 60, 1'b0);   // R4 head 1 skew, random stalls
    run_track(42, 1'b1, 100, 1'b1);  // R9 R11 disturbances
    run_track(5, 1'b0, 30, 1'b0);    // heavy stalls
    finish_run();
  end

endmodule